// File: doc/BRIEF.md
# Interrupt Entry and Return Stacking Sequencer

This block works beside a small 16-bit processor core and drives a shared, word-addressed memory port on its behalf. At each instruction boundary the core reports its current program counter and status word. If global interrupt enable is set and any of the request lines is high, the sequencer takes the most urgent source. It pushes the program counter and then the status word onto the stack. It then fetches that source's vector word from a fixed table at the top of the address space and hands the core a new program counter. In the same cycle it hands back a status word with interrupt enable cleared.

The sequencer also carries out the stack traffic for three core operations: a subroutine call, a plain return, and a return from interrupt. The stack pointer lives in the block. Every memory access waits on a ready handshake, so slow memory only stretches the sequence. All results reach the core as one-cycle load pulses.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset the sequencer is idle (`busy` low), issues no memory request, raises no acknowledge or load pulse, and the stack pointer equals `SP_INIT` (default 0x0200).
- R2: Source i uses the vector word at address 0xFFE0 + 2*i. When several sources are pending, the one with the highest index wins (its vector sits at the higher word address).
- R3: An interrupt is taken only in a cycle where `at_boundary` is high and status bit 3 (global interrupt enable) of `core_sr` is set. Otherwise no memory access starts and `busy` stays low.
- R4: Interrupt entry writes the program counter to SP-2 and then the status word to SP-4, in that order. It leaves the stack pointer at SP-4.
- R5: On completion of the entry, `pc_load` pulses with the vector word on `pc_value`. In the same cycle `sr_load` pulses with the saved status word, bit 3 cleared, on `sr_value`.
- R6: `irq_ack` is a one-hot, single-cycle pulse for the serviced source. It is raised in the same cycle as the `pc_load` that delivers that source's vector.
- R7: Return from interrupt (`core_op` = 3) reads the status word at SP and then the program counter at SP+2. It leaves SP+4 and pulses `sr_load` and `pc_load` together with the two words read.
- R8: A call (`core_op` = 1) writes `core_pc` to SP-2, leaves SP-2, and pulses `pc_load` with `call_target`, without `sr_load`.
- R9: A plain return (`core_op` = 2) reads the program counter at SP, leaves SP+2, and pulses `pc_load` with the word read.
- R10: Each memory access keeps `mem_req`, address, direction and write data stable until `mem_ready` is high. With W wait cycles per access, every access takes W+1 cycles.
- R11: When an interrupt and a core operation arrive at the same boundary, the interrupt is taken and the operation is dropped. A boundary presented while `busy` is high is ignored.
- R12: The stack pointer stays even at all times, and each push or pop moves it by exactly two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 16 | Interrupt request lines, bit i uses vector 0xFFE0+2i |
| irq_ack | output | 16 | One-hot acknowledge pulse for the serviced source |
| at_boundary | input | 1 | Core is at an instruction boundary this cycle |
| core_op | input | 2 | 0 none, 1 call, 2 return, 3 return from interrupt |
| core_pc | input | 16 | Current or return program counter from the core |
| core_sr | input | 16 | Current status word from the core, bit 3 is interrupt enable |
| call_target | input | 16 | Destination address of a call |
| busy | output | 1 | A sequence is in progress |
| pc_load | output | 1 | Load `pc_value` into the core program counter |
| pc_value | output | 16 | New program counter |
| sr_load | output | 1 | Load `sr_value` into the core status word |
| sr_value | output | 16 | New status word |
| sp_value | output | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word accessed |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the access this cycle |

## Verification
The assertions take for granted that the memory never raises `mem_ready` without a pending request, and that `core_pc` and `core_sr` are stable in the boundary cycle. They also assume that `SP_INIT` is even. The stimulus drives every core input at falling edges and holds the request lines until the acknowledge is seen. Its memory model raises ready only after a chosen number of wait cycles on an active request. Each scenario runs with a different wait count, and the stack is never driven outside the region the model stores.

// File: rtl/isq_pkg.sv
package isq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_PC = 3'd1,
        ST_PUSH_SR = 3'd2,
        ST_VEC     = 3'd3,
        ST_POP_SR  = 3'd4,
        ST_POP_PC  = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2,
        OP_RETI = 2'd3
    } core_op_e;
endpackage

// File: rtl/isq_prio.sv
module isq_prio #(
    parameter int NSRC = 16,
    localparam int IW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    output logic            any,
    output logic [IW-1:0]   idx
);
    logic [NSRC-1:0] hit;

    // hit[i] is set when req[i] is high and no higher index is pending
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_hit
            if (g == NSRC - 1) begin : g_top
                assign hit[g] = req[g];
            end else begin : g_low
                assign hit[g] = req[g] && (req[NSRC-1:g+1] == '0);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (hit[i]) idx = IW'(i);
        end
    end

    assign any = |req;

    // R2
    prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req >> idx) == NSRC'(1))));
endmodule

// File: rtl/isq_sp.sv
module isq_sp #(
    parameter int          W       = 16,
    parameter logic [15:0] SP_INIT = 16'h0200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_done,
    input  logic         pop_done,
    output logic [W-1:0] sp,
    output logic [W-1:0] sp_dec
);
    localparam logic [W-1:0] STEP = W'(2);

    logic [W-1:0] sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (push_done)     sp_d = sp_q - STEP;
        else if (pop_done) sp_d = sp_q + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= W'(SP_INIT);
        else        sp_q <= sp_d;
    end

    assign sp     = sp_q;
    assign sp_dec = sp_q - STEP;

    // R12
    sp_even_chk: assert property (@(posedge clk) disable iff (!rst_n) sp_q[0] == 1'b0);
    // R12
    sp_push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_done |=> sp_q == $past(sp_q) - STEP);
    // R12
    sp_pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_done |=> sp_q == $past(sp_q) + STEP);
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import isq_pkg::*;
#(
    parameter int          NSRC     = 16,
    parameter int          W        = 16,
    parameter int          GIE_BIT  = 3,
    parameter logic [15:0] VEC_BASE = 16'hFFE0,
    parameter logic [15:0] SP_INIT  = 16'h0200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    output logic [NSRC-1:0] irq_ack,
    input  logic            at_boundary,
    input  logic [1:0]      core_op,
    input  logic [W-1:0]    core_pc,
    input  logic [W-1:0]    core_sr,
    input  logic [W-1:0]    call_target,
    output logic            busy,
    output logic            pc_load,
    output logic [W-1:0]    pc_value,
    output logic            sr_load,
    output logic [W-1:0]    sr_value,
    output logic [W-1:0]    sp_value,
    output logic            mem_req,
    output logic            mem_we,
    output logic [W-1:0]    mem_addr,
    output logic [W-1:0]    mem_wdata,
    input  logic [W-1:0]    mem_rdata,
    input  logic            mem_ready
);
    localparam int           IW       = $clog2(NSRC);
    localparam logic [W-1:0] GIE_MASK = W'(1) << GIE_BIT;

    typedef struct packed {
        seq_state_e      state;
        logic            is_irq;
        logic            with_sr;
        logic [W-1:0]    pc_sav;
        logic [W-1:0]    sr_sav;
        logic [W-1:0]    tgt;
        logic [IW-1:0]   idx;
        logic [NSRC-1:0] ack;
        logic            pc_load;
        logic [W-1:0]    pc_val;
        logic            sr_load;
        logic [W-1:0]    sr_val;
    } seq_regs_t;

    seq_regs_t    d, q;
    logic         src_any;
    logic [IW-1:0] src_idx;
    logic [W-1:0] sp, sp_dec;
    logic         xfer, push_done, pop_done;

    isq_prio #(.NSRC(NSRC)) u_prio (
        .clk (clk),
        .rst_n (rst_n),
        .req (irq_req),
        .any (src_any),
        .idx (src_idx)
    );

    isq_sp #(.W(W), .SP_INIT(SP_INIT)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_done (push_done),
        .pop_done  (pop_done),
        .sp        (sp),
        .sp_dec    (sp_dec)
    );

    // memory port driven from the registered state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (q.state)
            ST_PUSH_PC: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_dec; mem_wdata = q.pc_sav;
            end
            ST_PUSH_SR: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_dec; mem_wdata = q.sr_sav;
            end
            ST_VEC: begin
                mem_req  = 1'b1;
                mem_addr = W'(VEC_BASE) + W'({q.idx, 1'b0});
            end
            ST_POP_SR, ST_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = sp;
            end
            default: ;
        endcase
    end

    assign xfer      = mem_req && mem_ready;
    assign push_done = xfer && mem_we;
    assign pop_done  = xfer && (q.state == ST_POP_SR || q.state == ST_POP_PC);

    always_comb begin
        d         = q;
        d.ack     = '0;
        d.pc_load = 1'b0;
        d.sr_load = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (at_boundary) begin
                    if (core_sr[GIE_BIT] && src_any) begin
                        d.state   = ST_PUSH_PC;
                        d.is_irq  = 1'b1;
                        d.pc_sav  = core_pc;
                        d.sr_sav  = core_sr;
                        d.idx     = src_idx;
                    end else begin
                        unique case (core_op_e'(core_op))
                            OP_CALL: begin
                                d.state  = ST_PUSH_PC;
                                d.is_irq = 1'b0;
                                d.pc_sav = core_pc;
                                d.tgt    = call_target;
                            end
                            OP_RET: begin
                                d.state   = ST_POP_PC;
                                d.with_sr = 1'b0;
                            end
                            OP_RETI: begin
                                d.state   = ST_POP_SR;
                                d.with_sr = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            ST_PUSH_PC: begin
                if (xfer) begin
                    if (q.is_irq) begin
                        d.state = ST_PUSH_SR;
                    end else begin
                        d.state   = ST_IDLE;
                        d.pc_load = 1'b1;
                        d.pc_val  = q.tgt;
                    end
                end
            end
            ST_PUSH_SR: begin
                if (xfer) d.state = ST_VEC;
            end
            ST_VEC: begin
                if (xfer) begin
                    d.state   = ST_IDLE;
                    d.ack     = NSRC'(1) << q.idx;
                    d.pc_load = 1'b1;
                    d.pc_val  = mem_rdata;
                    d.sr_load = 1'b1;
                    d.sr_val  = q.sr_sav & ~GIE_MASK;
                end
            end
            ST_POP_SR: begin
                if (xfer) begin
                    d.state  = ST_POP_PC;
                    d.sr_sav = mem_rdata;
                end
            end
            ST_POP_PC: begin
                if (xfer) begin
                    d.state   = ST_IDLE;
                    d.pc_load = 1'b1;
                    d.pc_val  = mem_rdata;
                    d.sr_load = q.with_sr;
                    d.sr_val  = q.sr_sav;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.state != ST_IDLE);
    assign irq_ack  = q.ack;
    assign pc_load  = q.pc_load;
    assign pc_value = q.pc_val;
    assign sr_load  = q.sr_load;
    assign sr_value = q.sr_val;
    assign sp_value = sp;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R6
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq_ack));
    // R6
    ack_with_pc_chk: assert property (@(posedge clk) disable iff (!rst_n) (|irq_ack) |-> pc_load);
    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) (|irq_ack) |=> (irq_ack == '0));
    // R5
    gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |-> (sr_load && !sr_value[GIE_BIT]));
    // R3
    entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !at_boundary) |=> !busy);
    // R4
    vec_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_addr >= W'(VEC_BASE)) |-> $countones(irq_ack) == 0);
endmodule

// File: tb/irq_stack_seq_test.sv
module irq_stack_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic [15:0] irq_ack;
    logic        at_boundary = 1'b0;
    logic [1:0]  core_op = 2'd0;
    logic [15:0] core_pc = '0, core_sr = '0, call_target = '0;
    logic        busy, pc_load, sr_load, mem_req, mem_we, mem_ready;
    logic [15:0] pc_value, sr_value, sp_value, mem_addr, mem_wdata, mem_rdata;

    int errors = 0, checks = 0;
    int wait_n = 0, wcnt = 0;
    bit finished = 0;

    logic [15:0] stk [0:255];
    logic [15:0] w_addr [0:7];
    logic [15:0] w_data [0:7];
    logic [15:0] r_addr [0:7];
    int w_n, r_n, ev_n, sr_n, ack_n, busy_n;
    logic [15:0] ev_pc, ev_sr, ev_ack;

    always #10 clk = ~clk;

    irq_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
        .at_boundary(at_boundary), .core_op(core_op), .core_pc(core_pc),
        .core_sr(core_sr), .call_target(call_target), .busy(busy),
        .pc_load(pc_load), .pc_value(pc_value), .sr_load(sr_load),
        .sr_value(sr_value), .sp_value(sp_value), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // memory model: vector word = 0x8000 | (source index << 8)
    assign mem_ready = mem_req && (wcnt >= wait_n);
    assign mem_rdata = (mem_addr >= 16'hFFE0) ? (16'h8000 | {4'h0, mem_addr[4:1], 8'h00})
                                               : stk[mem_addr[8:1]];

    always @(posedge clk) begin
        if (!mem_req || mem_ready) wcnt <= 0;
        else wcnt <= wcnt + 1;
    end

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                stk[mem_addr[8:1]] = mem_wdata;
                if (w_n < 8) begin w_addr[w_n] = mem_addr; w_data[w_n] = mem_wdata; end
                w_n = w_n + 1;
            end else begin
                if (r_n < 8) r_addr[r_n] = mem_addr;
                r_n = r_n + 1;
            end
        end
        if (pc_load) begin ev_n = ev_n + 1; ev_pc = pc_value; end
        if (sr_load) begin sr_n = sr_n + 1; ev_sr = sr_value; end
        if (|irq_ack) begin ack_n = ack_n + 1; ev_ack = irq_ack; end
        if (busy) busy_n = busy_n + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        w_n = 0; r_n = 0; ev_n = 0; sr_n = 0; ack_n = 0; busy_n = 0;
        ev_pc = '0; ev_sr = '0; ev_ack = '0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] pc, input logic [15:0] sr,
                          input logic [15:0] tgt);
        clear_logs();
        @(negedge clk);
        at_boundary = 1'b1; core_op = op; core_pc = pc; core_sr = sr; call_target = tgt;
        @(negedge clk);
        at_boundary = 1'b0; core_op = 2'd0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 ack", irq_ack, 0);
        chk("R1 pc_load", pc_load, 0);
        chk("R1 sp", sp_value, 16'h0200);
    endtask

    task automatic t_gate();
        wait_n = 0;
        irq_req = 16'h0010;
        run_op(2'd0, 16'h1000, 16'h0001, '0);
        chk("R3 no entry without enable", w_n + r_n + busy_n, 0);
        clear_logs();
        core_sr = 16'h0008;
        repeat (5) @(negedge clk);
        chk("R3 no entry without boundary", w_n + busy_n, 0);
        irq_req = '0;
    endtask

    task automatic t_entry_single();
        wait_n = 0;
        irq_req = 16'h0020;
        run_op(2'd0, 16'h3456, 16'h010B, '0);
        irq_req = '0;
        chk("R4 writes", w_n, 2);
        chk("R4 pc slot", {w_addr[0], w_data[0]}, {16'h01FE, 16'h3456});
        chk("R4 sr slot", {w_addr[1], w_data[1]}, {16'h01FC, 16'h010B});
        chk("R2 vector addr", r_addr[0], 16'hFFEA);
        chk("R5 new pc", ev_pc, 16'h8500);
        chk("R5 new sr", ev_sr, 16'h0103);
        chk("R6 ack", {ack_n[15:0], ev_ack}, {16'd1, 16'h0020});
        chk("R4 sp", sp_value, 16'h01FC);
    endtask

    task automatic t_entry_multi();
        wait_n = 3;
        irq_req = 16'h4204;
        run_op(2'd0, 16'h7000, 16'h0009, '0);
        irq_req = '0;
        chk("R2 winner vector", r_addr[0], 16'hFFFC);
        chk("R2 ack", ev_ack, 16'h4000);
        chk("R5 pc", ev_pc, 16'h8E00);
        chk("R5 sr", ev_sr, 16'h0001);
        chk("R10 busy cycles", busy_n, 12);
        chk("R4 order", {w_addr[0], w_addr[1]}, {16'h01FA, 16'h01F8});
        chk("R4 sp", sp_value, 16'h01F8);
    endtask

    task automatic t_reti();
        wait_n = 1;
        run_op(2'd3, 16'h0000, 16'h0000, '0);
        chk("R7 read order", {r_addr[0], r_addr[1]}, {16'h01F8, 16'h01FA});
        chk("R7 sr", {sr_n[15:0], ev_sr}, {16'd1, 16'h0009});
        chk("R7 pc", ev_pc, 16'h7000);
        chk("R7 sp", sp_value, 16'h01FC);
        chk("R10 busy cycles", busy_n, 4);
        run_op(2'd3, 16'h0000, 16'h0000, '0);
        chk("R7 second sr", ev_sr, 16'h010B);
        chk("R7 second pc", ev_pc, 16'h3456);
        chk("R7 second sp", sp_value, 16'h0200);
    endtask

    task automatic t_call_ret();
        wait_n = 2;
        run_op(2'd1, 16'h1234, 16'h0008, 16'h5000);
        chk("R8 write", {w_addr[0], w_data[0]}, {16'h01FE, 16'h1234});
        chk("R8 pc", ev_pc, 16'h5000);
        chk("R8 no sr load", sr_n, 0);
        chk("R8 sp", sp_value, 16'h01FE);
        run_op(2'd2, 16'h0000, 16'h0008, '0);
        chk("R9 read", r_addr[0], 16'h01FE);
        chk("R9 pc", {ev_n[15:0], ev_pc}, {16'd1, 16'h1234});
        chk("R9 sp", sp_value, 16'h0200);
    endtask

    task automatic t_conflict();
        wait_n = 4;
        irq_req = 16'h0001;
        clear_logs();
        @(negedge clk);
        at_boundary = 1'b1; core_op = 2'd1; core_pc = 16'h2222; core_sr = 16'h0008;
        call_target = 16'h6000;
        @(negedge clk);
        at_boundary = 1'b0; core_op = 2'd0;
        @(negedge clk);
        at_boundary = 1'b1; core_op = 2'd2;   // presented while busy
        @(negedge clk);
        at_boundary = 1'b0; core_op = 2'd0;
        while (busy) @(negedge clk);
        irq_req = '0;
        repeat (3) @(negedge clk);
        chk("R11 irq wins", {ack_n[15:0], ev_ack}, {16'd1, 16'h0001});
        chk("R11 pc", ev_pc, 16'h8000);
        chk("R11 busy boundary ignored", {w_n[7:0], r_n[7:0], ev_n[7:0]}, {8'd2, 8'd1, 8'd1});
        chk("R11 sp", sp_value, 16'h01FC);
        run_op(2'd3, 16'h0000, 16'h0000, '0);
        chk("R11 restored pc", ev_pc, 16'h2222);
        chk("R12 sp", sp_value, 16'h0200);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = '0;
        clear_logs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_entry_single();
        t_entry_multi();
        t_reti();
        t_call_ret();
        t_conflict();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end
endmodule